// File: doc/BRIEF.md
# Timing and Trigger Command Decoder

This block turns the per-crossing control symbols of a timing link into trigger strobes and counters. A symbol arrives once per bunch-crossing as a parallel word of up to 8 bits, together with a valid flag, in the design clock domain. The design clock runs four times faster than the crossing rate, so `sym_valid` is normally high on one cycle in four. Depending on `link_mode`, the link is 2, 4 or 8 bits wide, and each width has its own bit map.

The block produces one-cycle strobes for Level-1 Accept, bunch-counter reset, event-counter reset and up to five user commands. It keeps a local bunch-crossing number and a Level-1 event count.

The latency of an Accept is not fixed, so the link also carries, bit by bit on a serial channel, the crossing number that belongs to each Accept. The block rebuilds that number and compares it with the local number it captured when the Accept arrived. The symbol input has no ready signal, because a timing link cannot be paused. The received-number output is a valid-only pulse, and the consumer must take it on the cycle it is high.

Top module: `ttc_link_decoder`

## Requirements
- R1: With `link_mode`=0 (2-bit link), symbol bit 0 is the Accept and bit 1 is the serial channel. Bits 2 to 7 are ignored, and no reset or user strobe is ever produced.
- R2: With `link_mode`=1 (4-bit link), bit 0 is the Accept, bit 1 is the bunch reset and bit 2 is the event reset. Bit 3 drives `user_stb[0]` when `bchan_sel`=0 and is the serial channel when `bchan_sel`=1. Bits 4 to 7 are ignored.
- R3: With `link_mode`=2 or 3 (8-bit link), bits 0 to 3 follow R2, and bits 4, 5, 6 and 7 drive `user_stb[1]`, `user_stb[2]`, `user_stb[3]` and `user_stb[4]`.
- R4: A valid symbol with a command bit set raises that strobe for exactly the one cycle after the accepting clock edge. Strobes are low at all other times, and symbols presented with `sym_valid` low have no effect.
- R5: `bcid` holds the crossing number of the latest symbol. A symbol carrying a bunch reset sets it to 0. Any other symbol advances it by one, and 3563 is followed by 0.
- R6: On each symbol, `evt_cnt` becomes (0 if the symbol carries an event reset, else `evt_cnt`) plus 1 if the symbol carries an Accept. The counter is 24 bits wide and wraps.
- R7: When idle, the serial receiver waits for a 1 (start bit). The next 12 serial bits form a crossing number, MSB first. One cycle after the symbol with the 12th bit, `rx_valid` is high for one cycle with the number on `rx_bcid`, and the receiver returns to idle.
- R8: An Accept captures the `bcid` value of its own symbol. While `rx_valid` is high, `bcid_mismatch` is 1 exactly when `rx_bcid` differs from the most recently captured value. `bcid_mismatch` is always 0 when `rx_valid` is low.
- R9: After reset, all strobes, `bcid`, `evt_cnt`, `rx_valid` and `bcid_mismatch` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_mode | input | 2 | Link width: 0 = 2-bit, 1 = 4-bit, 2 and 3 = 8-bit |
| bchan_sel | input | 1 | On 4- and 8-bit links, use bit 3 as the serial channel |
| sym_valid | input | 1 | Symbol present this cycle |
| sym_data | input | 8 | Symbol bits |
| l1a_stb | output | 1 | Level-1 Accept strobe |
| bcr_stb | output | 1 | Bunch-counter reset strobe |
| ecr_stb | output | 1 | Event-counter reset strobe |
| user_stb | output | 5 | User command strobes |
| bcid | output | 12 | Local crossing number |
| evt_cnt | output | 24 | Level-1 event count |
| rx_bcid | output | 12 | Crossing number received on the serial channel |
| rx_valid | output | 1 | `rx_bcid` is valid this cycle |
| bcid_mismatch | output | 1 | Received number differs from the captured one |

## Verification
The bench sweeps every 8-bit symbol value under every link mode and both settings of `bchan_sel`. Under this sweep, a wrong bit map would show up as a strobe on the wrong pin or as a reset that leaks into the 2-bit link. Symbol inputs are set to all ones on the cycles when `sym_valid` is low, so a decoder that ignores `sym_valid` would emit extra strobes. The bench also runs the crossing counter past 3563, where an off-by-one wrap would give 3564 or skip 0. It sends serial frames that match and that do not match the captured number, in both the 2- and 4-bit layouts. It also sends a frame on bit 3 while that bit is configured as a user bit, which a design that routes the bit wrongly would treat as a real frame.

// File: rtl/ttc_pkg.sv
package ttc_pkg;
  localparam logic [1:0] LINK_2B = 2'd0;
  localparam logic [1:0] LINK_4B = 2'd1;

  localparam int USER_W = 5;

  typedef struct packed {
    logic              l1a;
    logic              bcr;
    logic              ecr;
    logic [USER_W-1:0] user;
    logic              bchan;
  } ttc_cmd_t;
endpackage

// File: rtl/ttc_sym_map.sv
module ttc_sym_map
  import ttc_pkg::*;
(
  input  logic [1:0] link_mode,
  input  logic       bchan_sel,
  input  logic [7:0] sym,
  output ttc_cmd_t   cmd
);
  logic narrow;
  logic wide;
  logic [USER_W-1:0] user_w;

  assign narrow = (link_mode == LINK_2B);
  assign wide   = !narrow && (link_mode != LINK_4B);

  assign user_w[0] = !narrow && !bchan_sel && sym[3];

  // upper nibble becomes user strobes 1..4 on the 8-bit link
  for (genvar i = 1; i < USER_W; i++) begin : g_user
    assign user_w[i] = wide && sym[3+i];
  end

  always_comb begin
    cmd       = '0;
    cmd.l1a   = sym[0];
    cmd.bcr   = !narrow && sym[1];
    cmd.ecr   = !narrow && sym[2];
    cmd.user  = user_w;
    cmd.bchan = narrow ? sym[1] : (bchan_sel && sym[3]);
  end
endmodule

// File: rtl/ttc_bc_counter.sv
module ttc_bc_counter #(
  parameter int BCID_W = 12,
  parameter int BC_MAX = 3563,
  parameter int EVT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bcr,
  input  logic              ecr,
  input  logic              l1a,
  output logic [BCID_W-1:0] bcid,
  output logic [BCID_W-1:0] bcid_next,
  output logic [EVT_W-1:0]  evt_cnt
);
  localparam logic [BCID_W-1:0] LAST_BC = BCID_W'(BC_MAX);

  always_comb begin
    if (bcr)
      bcid_next = '0;
    else if (bcid == LAST_BC)
      bcid_next = '0;
    else
      bcid_next = bcid + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcid    <= '0;
      evt_cnt <= '0;
    end else if (tick) begin
      bcid    <= bcid_next;
      evt_cnt <= (ecr ? '0 : evt_cnt) + EVT_W'(l1a);
    end
  end
endmodule

// File: rtl/ttc_bchan_rx.sv
module ttc_bchan_rx #(
  parameter int BCID_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bit_in,
  input  logic              l1a,
  input  logic [BCID_W-1:0] l1a_bcid,
  output logic [BCID_W-1:0] rx_bcid,
  output logic              rx_valid,
  output logic              mismatch
);
  localparam int CNT_W = $clog2(BCID_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BCID_W - 1);

  logic              busy;
  logic [CNT_W-1:0]  cnt;
  logic [BCID_W-1:0] shreg;
  logic [BCID_W-1:0] captured;
  logic [BCID_W-1:0] word;

  assign word = {shreg[BCID_W-2:0], bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
      captured <= '0;
      rx_bcid  <= '0;
      rx_valid <= 1'b0;
      mismatch <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      mismatch <= 1'b0;
      if (tick) begin
        if (l1a)
          captured <= l1a_bcid;
        if (!busy) begin
          busy <= bit_in;
          cnt  <= '0;
        end else begin
          shreg <= word;
          cnt   <= cnt + 1'b1;
          if (cnt == LAST_BIT) begin
            busy     <= 1'b0;
            rx_valid <= 1'b1;
            rx_bcid  <= word;
            mismatch <= (word != captured);
          end
        end
      end
    end
  end
endmodule

// File: rtl/ttc_link_decoder.sv
module ttc_link_decoder
  import ttc_pkg::*;
#(
  parameter int BCID_W = 12,
  parameter int BC_MAX = 3563,
  parameter int EVT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        link_mode,
  input  logic              bchan_sel,
  input  logic              sym_valid,
  input  logic [7:0]        sym_data,
  output logic              l1a_stb,
  output logic              bcr_stb,
  output logic              ecr_stb,
  output logic [USER_W-1:0] user_stb,
  output logic [BCID_W-1:0] bcid,
  output logic [EVT_W-1:0]  evt_cnt,
  output logic [BCID_W-1:0] rx_bcid,
  output logic              rx_valid,
  output logic              bcid_mismatch
);
  ttc_cmd_t          cmd;
  logic [BCID_W-1:0] bcid_next;

  ttc_sym_map u_map (
    .link_mode (link_mode),
    .bchan_sel (bchan_sel),
    .sym       (sym_data),
    .cmd       (cmd)
  );

  ttc_bc_counter #(
    .BCID_W (BCID_W),
    .BC_MAX (BC_MAX),
    .EVT_W  (EVT_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sym_valid),
    .bcr       (cmd.bcr),
    .ecr       (cmd.ecr),
    .l1a       (cmd.l1a),
    .bcid      (bcid),
    .bcid_next (bcid_next),
    .evt_cnt   (evt_cnt)
  );

  ttc_bchan_rx #(
    .BCID_W (BCID_W)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sym_valid),
    .bit_in   (cmd.bchan),
    .l1a      (cmd.l1a),
    .l1a_bcid (bcid_next),
    .rx_bcid  (rx_bcid),
    .rx_valid (rx_valid),
    .mismatch (bcid_mismatch)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l1a_stb  <= 1'b0;
      bcr_stb  <= 1'b0;
      ecr_stb  <= 1'b0;
      user_stb <= '0;
    end else begin
      l1a_stb  <= sym_valid && cmd.l1a;
      bcr_stb  <= sym_valid && cmd.bcr;
      ecr_stb  <= sym_valid && cmd.ecr;
      user_stb <= sym_valid ? cmd.user : '0;
    end
  end
endmodule

// File: rtl/ttc_link_decoder_chk.sv
module ttc_link_decoder_chk #(
  parameter int BCID_W = 12,
  parameter int BC_MAX = 3563,
  parameter int EVT_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        link_mode,
  input logic              sym_valid,
  input logic              l1a_stb,
  input logic              bcr_stb,
  input logic              ecr_stb,
  input logic [BCID_W-1:0] bcid,
  input logic [EVT_W-1:0]  evt_cnt,
  input logic              rx_valid,
  input logic              bcid_mismatch
);
  AST_STB_AFTER_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
    (l1a_stb || bcr_stb || ecr_stb) |-> $past(sym_valid)); // R4
  AST_BCID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sym_valid) |-> $stable(bcid)); // R4
  AST_BCID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bcid <= BCID_W'(BC_MAX)); // R5
  AST_BCR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bcr_stb |-> bcid == '0); // R5
  AST_NARROW_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (bcr_stb || ecr_stb) |-> $past(link_mode) != 2'd0); // R1
  AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ecr_stb && !l1a_stb) |-> evt_cnt == '0); // R6
  AST_EVT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (l1a_stb && !ecr_stb) |-> evt_cnt == EVT_W'($past(evt_cnt) + 1'b1)); // R6
  AST_MISMATCH_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    bcid_mismatch |-> rx_valid); // R8
  AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R7
endmodule

bind ttc_link_decoder ttc_link_decoder_chk #(
  .BCID_W (BCID_W),
  .BC_MAX (BC_MAX),
  .EVT_W  (EVT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .link_mode     (link_mode),
  .sym_valid     (sym_valid),
  .l1a_stb       (l1a_stb),
  .bcr_stb       (bcr_stb),
  .ecr_stb       (ecr_stb),
  .bcid          (bcid),
  .evt_cnt       (evt_cnt),
  .rx_valid      (rx_valid),
  .bcid_mismatch (bcid_mismatch)
);

// File: tb/ttc_link_decoder_tb.sv
module ttc_link_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  link_mode = 2'd0;
  logic        bchan_sel = 1'b0;
  logic        sym_valid = 1'b0;
  logic [7:0]  sym_data = 8'h00;
  logic        l1a_stb, bcr_stb, ecr_stb;
  logic [4:0]  user_stb;
  logic [11:0] bcid;
  logic [23:0] evt_cnt;
  logic [11:0] rx_bcid;
  logic        rx_valid, bcid_mismatch;

  int errors = 0;
  int checks = 0;
  int m_bcid = 0;
  int m_evt  = 0;
  logic        s_rx_valid, s_mm;
  logic [11:0] s_rx_bcid;

  always #10 clk = ~clk;

  ttc_link_decoder u_dut (
    .clk (clk), .rst_n (rst_n), .link_mode (link_mode), .bchan_sel (bchan_sel),
    .sym_valid (sym_valid), .sym_data (sym_data),
    .l1a_stb (l1a_stb), .bcr_stb (bcr_stb), .ecr_stb (ecr_stb), .user_stb (user_stb),
    .bcid (bcid), .evt_cnt (evt_cnt), .rx_bcid (rx_bcid), .rx_valid (rx_valid),
    .bcid_mismatch (bcid_mismatch)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sym_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_bcid = 0;
    m_evt  = 0;
  endtask

  // one symbol per four design cycles; idle cycles carry all-ones data
  task automatic send_sym(input logic [7:0] d);
    logic       e_l1a, e_bcr, e_ecr;
    logic [4:0] e_user;
    string      tag;
    e_l1a     = d[0];
    e_bcr     = (link_mode != 2'd0) && d[1];
    e_ecr     = (link_mode != 2'd0) && d[2];
    e_user[0] = (link_mode != 2'd0) && !bchan_sel && d[3];
    e_user[4:1] = (link_mode >= 2'd2) ? d[7:4] : 4'h0;
    tag = (link_mode == 2'd0) ? "R1" : (link_mode == 2'd1) ? "R2" : "R3";
    m_bcid = e_bcr ? 0 : ((m_bcid == 3563) ? 0 : m_bcid + 1);
    m_evt  = ((e_ecr ? 0 : m_evt) + int'(e_l1a)) & 24'hFFFFFF;
    @(negedge clk);
    sym_valid = 1'b1;
    sym_data  = d;
    @(negedge clk);
    sym_valid = 1'b0;
    sym_data  = 8'hFF;
    check(tag, {24'h0, l1a_stb, bcr_stb, ecr_stb, user_stb}, {24'h0, e_l1a, e_bcr, e_ecr, e_user});
    check("R5", 32'(bcid), 32'(m_bcid));
    check("R6", 32'(evt_cnt), 32'(m_evt));
    s_rx_valid = rx_valid;
    s_rx_bcid  = rx_bcid;
    s_mm       = bcid_mismatch;
    @(negedge clk);
    check("R4", {24'h0, l1a_stb, bcr_stb, ecr_stb, user_stb}, 32'h0);
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [11:0] val, input int pos, output logic seen);
    seen = 1'b0;
    send_sym(8'(1 << pos));
    seen = seen | s_rx_valid;
    for (int i = 11; i >= 0; i--) begin
      send_sym(8'(int'(val[i]) << pos));
      if (i > 0) seen = seen | s_rx_valid;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic seen;
    logic [11:0] cap;
    do_reset();
    // R9 reset state
    check("R9", {l1a_stb, bcr_stb, ecr_stb, user_stb, rx_valid, bcid_mismatch}, 32'h0);
    check("R9", 32'(bcid), 32'h0);
    check("R9", 32'(evt_cnt), 32'h0);

    // sweep every symbol under every mode and channel selection (R1 R2 R3 R4 R5 R6)
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        link_mode = 2'(m);
        bchan_sel = s[0];
        for (int d = 0; d < 256; d++) send_sym(8'(d));
      end
    end

    // R5 wrap after 3563
    do_reset();
    link_mode = 2'd1;
    bchan_sel = 1'b0;
    for (int i = 0; i < 3563; i++) send_sym(8'h00);
    check("R5", 32'(bcid), 32'd3563);
    send_sym(8'h00);
    check("R5", 32'(bcid), 32'd0);

    // R7 R8 frames on bit 3 of the 4-bit link
    do_reset();
    link_mode = 2'd1;
    bchan_sel = 1'b1;
    repeat (5) send_sym(8'h00);
    send_sym(8'h01);
    cap = 12'd6;
    check("R8", 32'(bcid), 32'(cap));
    send_frame(cap, 3, seen);
    check("R7", 32'(seen), 32'h0);
    check("R7", {19'h0, s_rx_valid, s_rx_bcid}, {19'h0, 1'b1, cap});
    check("R8", 32'(s_mm), 32'h0);
    send_frame(cap ^ 12'h801, 3, seen);
    check("R7", {19'h0, s_rx_valid, s_rx_bcid}, {19'h0, 1'b1, cap ^ 12'h801});
    check("R8", 32'(s_mm), 32'h1);
    check("R7", 32'(rx_valid), 32'h0);

    // R2 bit 3 as a user bit never starts a frame
    bchan_sel = 1'b0;
    send_frame(12'hFFF, 3, seen);
    check("R2", 32'(seen | s_rx_valid), 32'h0);

    // R1 frames on bit 1 of the 2-bit link
    link_mode = 2'd0;
    repeat (2) send_sym(8'h00);
    send_sym(8'h01);
    cap = 12'(m_bcid);
    send_frame(cap, 1, seen);
    check("R1", {19'h0, s_rx_valid, s_rx_bcid}, {19'h0, 1'b1, cap});
    check("R8", 32'(s_mm), 32'h0);
    send_frame(12'hA5C, 1, seen);
    check("R1", {19'h0, s_rx_valid, s_rx_bcid}, {19'h0, 1'b1, 12'hA5C});
    check("R8", 32'(s_mm), 32'(12'hA5C != cap));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule